// File: doc/BRIEF.md
# Dual-Edge Pin Interrupt Unit

This block watches a bank of already-synchronized pin inputs and turns selected transitions into latched per-pin pending flags, merged into a single interrupt line. Each pin can be armed for rising transitions, falling transitions or both, through two independent enable masks. A transition is found by comparing a pin with its value on the previous clock. Only transitions are detected. A steady level never raises a flag.

Software reaches the block through a small word-addressed register bus. It arms the pins it cares about. When the interrupt line is high, it reads the pending word, handles the lowest set bit and then acknowledges that bit by writing a one to it at the acknowledge address. It repeats this until the pending word reads zero. A pending flag stays set until it is acknowledged. Disarming a pin stops new events from that pin but does not erase a flag already raised.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset both enable masks, the pending word and the interrupt output are all zero, and every register address reads zero.
- R2: When a pin goes from 0 to 1 and its bit in the rising enable mask (address 0, bit i is pin i) is set, pending bit i is set at that clock edge.
- R3: When a pin goes from 1 to 0 and its bit in the falling enable mask (address 1, bit i is pin i) is set, pending bit i is set at that clock edge.
- R4: A pin armed in both masks raises its pending bit on either transition.
- R5: A transition on a pin armed in neither mask for that direction leaves the pending word unchanged.
- R6: A pending bit stays set through further transitions and idle cycles until it is acknowledged, so software can service the lowest set bit repeatedly until the pending word (address 2) reads zero.
- R7: A bus write to address 3 clears every pending bit whose data bit is 1 and leaves the other bits alone. A write to the pending address 2 has no effect.
- R8: When an armed transition and an acknowledge of the same bit fall on the same clock edge, the bit stays set.
- R9: Clearing a mask bit keeps an existing pending bit and prevents new events on that pin.
- R10: The interrupt output is the OR of all pending bits, registered, so it follows the pending word one clock later.
- R11: A read strobe loads the addressed register into the read data, which is valid after that clock edge and holds until the next read. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Synchronized pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address: 0 rising mask, 1 falling mask, 2 pending, 3 acknowledge |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Registered read data |
| irq | output | 1 | Combined interrupt |

## Verification
A pin change applied before a clock edge shows up in the pending word at that same edge. The interrupt line follows one edge later. Read data reflects the register as it stood just before the edge that took the read strobe. A mask or acknowledge write takes effect at the edge that accepts it. The bench changes every input on the falling clock edge and samples on the next falling edge, so each check sits exactly one rising edge after its stimulus. For the interrupt line it checks both the low value one edge early and the high value at the due edge.

// File: rtl/pei_pkg.sv
package pei_pkg;

  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_RISE_EN = 2'd0,
    REG_FALL_EN = 2'd1,
    REG_PENDING = 2'd2,
    REG_ACK     = 2'd3
  } reg_sel_e;

  // Transition low-to-high between the previous and current sample
  function automatic logic went_high(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  // Transition high-to-low between the previous and current sample
  function automatic logic went_low(input logic cur, input logic prev);
    return ~cur & prev;
  endfunction

  // Next pending state: a new event overrides an acknowledge
  function automatic logic next_pending(input logic cur, input logic set,
                                        input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/pei_regfile.sv
module pei_regfile
  import pei_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]      wdata,
  input  logic [NPINS-1:0]      pending,
  output logic [NPINS-1:0]      rise_en,
  output logic [NPINS-1:0]      fall_en,
  output logic [NPINS-1:0]      ack_vec,
  output logic [NPINS-1:0]      rdata
);

  reg_sel_e         sel;
  logic [NPINS-1:0] rise_q;
  logic [NPINS-1:0] fall_q;
  logic [NPINS-1:0] rdata_q;
  logic [NPINS-1:0] rd_mux;

  assign sel = reg_sel_e'(addr);

  always_comb begin
    case (sel)
      REG_RISE_EN: rd_mux = rise_q;
      REG_FALL_EN: rd_mux = fall_q;
      REG_PENDING: rd_mux = pending;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q  <= '0;
      fall_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_en && sel == REG_RISE_EN) rise_q <= wdata;
      if (wr_en && sel == REG_FALL_EN) fall_q <= wdata;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign ack_vec = (wr_en && sel == REG_ACK) ? wdata : '0;
  assign rise_en = rise_q;
  assign fall_en = fall_q;
  assign rdata   = rdata_q;

endmodule

// File: rtl/pei_edge_detect.sv
module pei_edge_detect
  import pei_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] rise_en,
  input  logic [NPINS-1:0] fall_en,
  output logic [NPINS-1:0] evt_vec
);

  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] rise_hit;
  logic [NPINS-1:0] fall_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_in;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign rise_hit[g] = went_high(pin_in[g], prev_q[g]);
    assign fall_hit[g] = went_low(pin_in[g], prev_q[g]);
    assign evt_vec[g]  = (rise_hit[g] & rise_en[g]) | (fall_hit[g] & fall_en[g]);
  end

endmodule

// File: rtl/pei_pending.sv
module pei_pending
  import pei_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] evt_vec,
  input  logic [NPINS-1:0] ack_vec,
  output logic [NPINS-1:0] pending,
  output logic             irq
);

  logic [NPINS-1:0] pend_q;
  logic             irq_q;

  for (genvar g = 0; g < NPINS; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= next_pending(pend_q[g], evt_vec[g], ack_vec[g]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pend_q;
  end

  assign pending = pend_q;
  assign irq     = irq_q;

endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
  import pei_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPINS-1:0]      pin_in,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]      bus_wdata,
  output logic [NPINS-1:0]      bus_rdata,
  output logic                  irq
);

  logic [NPINS-1:0] rise_en;
  logic [NPINS-1:0] fall_en;
  logic [NPINS-1:0] ack_vec;
  logic [NPINS-1:0] evt_vec;
  logic [NPINS-1:0] pending;

  pei_regfile #(.NPINS(NPINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr),
    .rd_en   (bus_rd),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .pending (pending),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .ack_vec (ack_vec),
    .rdata   (bus_rdata)
  );

  pei_edge_detect #(.NPINS(NPINS)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_in  (pin_in),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .evt_vec (evt_vec)
  );

  pei_pending #(.NPINS(NPINS)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_vec (evt_vec),
    .ack_vec (ack_vec),
    .pending (pending),
    .irq     (irq)
  );

endmodule

// File: rtl/pin_edge_irq_chk.sv
module pin_edge_irq_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic [NPINS-1:0] rise_en,
  input logic [NPINS-1:0] fall_en,
  input logic [NPINS-1:0] evt_vec,
  input logic [NPINS-1:0] ack_vec,
  input logic [NPINS-1:0] pending
);

  p_irq_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|$past(pending)));

  p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pending) & ~$past(ack_vec)) & ~pending) == '0);

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ack_vec) & ~$past(evt_vec)) & pending) == '0);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt_vec) & ~pending) == '0);

  p_no_unarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending & ~$past(pending)) & ~($past(rise_en) | $past(fall_en))) == '0);

endmodule

bind pin_edge_irq pin_edge_irq_chk #(.NPINS(NPINS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq     (irq),
  .rise_en (rise_en),
  .fall_en (fall_en),
  .evt_vec (evt_vec),
  .ack_vec (ack_vec),
  .pending (pending)
);

// File: tb/test_pin_edge_irq.sv
module test_pin_edge_irq;
  localparam int NPINS = 32;
  localparam logic [1:0] A_RISE = 2'd0;
  localparam logic [1:0] A_FALL = 2'd1;
  localparam logic [1:0] A_PEND = 2'd2;
  localparam logic [1:0] A_ACK  = 2'd3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NPINS-1:0] pins = '0;
  logic             bus_wr = 1'b0;
  logic             bus_rd = 1'b0;
  logic [1:0]       bus_addr = '0;
  logic [NPINS-1:0] bus_wdata = '0;
  logic [NPINS-1:0] bus_rdata;
  logic             irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pin_edge_irq #(.NPINS(NPINS)) i_pin_edge_irq (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    step();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic setpins(input logic [31:0] v);
    pins = v;
    step();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'd0, irq}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reg reads zero", d, 32'd0);
    end
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wr(A_RISE, 32'h5);
    rd(A_RISE, d);
    chk("R11 rise mask readback", d, 32'h5);
    pins = 32'h7;
    step();
    chk("R10 irq not yet", {31'd0, irq}, 32'd0);
    step();
    chk("R10 irq due", {31'd0, irq}, 32'd1);
    rd(A_PEND, d);
    chk("R2 rising armed bits", d, 32'h5);
    setpins(32'h0);
    rd(A_PEND, d);
    chk("R2 falls unarmed", d, 32'h5);
    wr(A_ACK, 32'hFFFF_FFFF);
    step();
    chk("R10 irq drops", {31'd0, irq}, 32'd0);
    rd(A_PEND, d);
    chk("R7 ack all", d, 32'h0);
    wr(A_RISE, 32'h0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    wr(A_FALL, 32'h8000_0010);
    setpins(32'h8000_0010);
    rd(A_PEND, d);
    chk("R3 rise ignored", d, 32'h0);
    setpins(32'h0);
    rd(A_PEND, d);
    chk("R3 falling armed bits", d, 32'h8000_0010);
    wr(A_ACK, 32'hFFFF_FFFF);
    wr(A_FALL, 32'h0);
  endtask

  task automatic t_both();
    logic [31:0] d;
    wr(A_RISE, 32'h100);
    wr(A_FALL, 32'h100);
    setpins(32'h100);
    rd(A_PEND, d);
    chk("R4 rise", d, 32'h100);
    wr(A_ACK, 32'h100);
    rd(A_PEND, d);
    chk("R7 acked", d, 32'h0);
    setpins(32'h0);
    rd(A_PEND, d);
    chk("R4 fall", d, 32'h100);
    wr(A_ACK, 32'hFFFF_FFFF);
    wr(A_RISE, 32'h0);
    wr(A_FALL, 32'h0);
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    setpins(32'hFFFF_FFFF);
    setpins(32'h0);
    rd(A_PEND, d);
    chk("R5 unarmed toggles", d, 32'h0);
    chk("R5 irq quiet", {31'd0, irq}, 32'd0);
    wr(A_RISE, 32'h1);
    setpins(32'h1);
    wr(A_PEND, 32'h0);
    rd(A_PEND, d);
    chk("R7 pending write zero ignored", d, 32'h1);
    wr(A_PEND, 32'hFFFF_FFFF);
    rd(A_PEND, d);
    chk("R7 pending write ones ignored", d, 32'h1);
    rd(A_ACK, d);
    chk("R11 ack reads zero", d, 32'h0);
    setpins(32'h0);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    setpins(32'h1);
    setpins(32'h0);
    setpins(32'h1);
    for (int i = 0; i < 20; i++) step();
    rd(A_PEND, d);
    chk("R6 held", d, 32'h1);
    wr(A_ACK, 32'h2);
    rd(A_PEND, d);
    chk("R7 other bit ack", d, 32'h1);
    wr(A_ACK, 32'h1);
    rd(A_PEND, d);
    chk("R7 own bit ack", d, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    setpins(32'h0);
    pins = 32'h1; bus_wr = 1'b1; bus_addr = A_ACK; bus_wdata = 32'h1;
    step();
    bus_wr = 1'b0; bus_wdata = '0;
    rd(A_PEND, d);
    chk("R8 event beats ack", d, 32'h1);
    wr(A_RISE, 32'h3);
    pins = 32'h2; bus_wr = 1'b1; bus_addr = A_ACK; bus_wdata = 32'h1;
    step();
    bus_wr = 1'b0; bus_wdata = '0;
    rd(A_PEND, d);
    chk("R8 ack other bit with event", d, 32'h2);
    wr(A_ACK, 32'hFFFF_FFFF);
    wr(A_RISE, 32'h0);
    setpins(32'h0);
  endtask

  task automatic t_mask_keep();
    logic [31:0] d;
    wr(A_RISE, 32'h10);
    setpins(32'h10);
    wr(A_RISE, 32'h0);
    rd(A_PEND, d);
    chk("R9 pending kept after disarm", d, 32'h10);
    wr(A_ACK, 32'h10);
    setpins(32'h0);
    setpins(32'h10);
    rd(A_PEND, d);
    chk("R9 no new event after disarm", d, 32'h0);
    setpins(32'h0);
  endtask

  task automatic t_service();
    logic [31:0] d;
    int served;
    int last;
    bit order_ok;
    served = 0; last = -1; order_ok = 1;
    wr(A_RISE, 32'hFFFF_FFFF);
    setpins(32'h8421_0240);
    rd(A_PEND, d);
    while (d != 0 && served < 40) begin
      int low;
      low = 0;
      while (!d[low]) low++;
      if (low <= last) order_ok = 0;
      last = low;
      wr(A_ACK, 32'h1 << low);
      served++;
      rd(A_PEND, d);
    end
    chk("R6 service count", served, 32'd6);
    chk("R6 ascending order", {31'd0, order_ok}, 32'd1);
    chk("R6 drained", d, 32'h0);
    chk("R10 irq after drain", {31'd0, irq}, 32'd0);
    wr(A_RISE, 32'h0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_ignore();
    t_hold();
    t_set_wins();
    t_mask_keep();
    t_service();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule